// File: doc/BRIEF.md
# Three-wire configuration word loader

This block takes 24-bit configuration words from a three-line serial port (a data line, a shift clock and a latch strobe) and files each word into one of seven internal registers. Bits are shifted in most significant first. The rising edge of the latch strobe moves the whole word into the register named by an address code in its low bits. The address code is a prefix code whose length grows from 2 to 6 bits. The block holds the register file and presents the decoded fields as parallel outputs.

The three serial lines are treated as asynchronous to the system clock. Each line passes through a synchronizer and an edge detector in the system clock domain. The serial clock must therefore stay in each phase for more than `SYNC_STAGES + 1` system clock cycles.

A default-select bit in the main register decides where the intermediate-frequency (IF) divider fields come from. When the bit is set, they come from built-in default values. When it is clear, they come from two user registers. A seventh test register accepts writes but drives nothing.

Top module: `tri_wire_cfg_loader`

## Requirements
- R1: On each rising edge of `ser_clk`, the bit on `ser_data` enters the low end of a 24-bit shift register. After 24 edges, the first bit sent is bit 23 of the word and the last bit sent is bit 0.
- R2: Each rising edge of `ser_latch` copies the shifted word into the register its address code selects. The outputs show the new value a few system clocks later.
- R3: Address decoding, with bits listed from bit 0 upward:
    - bits[1:0] = 00 selects register 0, 01 selects register 1, and 10 selects register 2.
    - When bits[1:0] = 11, the count of consecutive ones starting at bit 0 picks the register: 2 ones selects register 3, 3 selects register 4, 4 selects register 5, and 5 selects register 6.
    - Register 2 gives its bits [23:2] on `aux_misc`. Register 3 gives its bits [23:3] on `loop_misc`.
- R4: Register 0 fields:
    - bit 23 is default-select, bit 22 is band select, bit 21 is lock-indicator enable and bit 20 is spur control.
    - bits [19:16] are the main B count, bits [15:13] the main A count and bits [12:2] the fractional numerator.
- R5: In register 1, bit 3 drives `main_en` and bit 2 drives `if_en`. Bits [23:4] appear on `ctrl_misc`.
- R6: While default-select is 0, the IF outputs come from the user registers:
    - `if_a` comes from register 4 bits [16:13].
    - `if_b` comes from register 4 bits [12:4].
    - `if_r` comes from register 5 bits [13:5].
- R7: While default-select is 1, `if_a`, `if_b` and `if_r` show the parameter defaults (9, 229 and 160).
- R8: Bits shifted without a rising edge of `ser_latch` change no output.
- R9: A write to register 6 changes no output. A word whose bits [5:0] are all ones is discarded.
- R10: After synchronous reset:
    - every output field is zero except default-select, which is 1, and the IF outputs show the defaults.
    - Register 4 and 5 contents written while defaults are selected are kept. They appear once default-select is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch strobe; rising edge commits the word |
| dflt_sel | output | 1 | Default-select bit of register 0 |
| band_sel | output | 1 | Band select bit |
| lock_ind_en | output | 1 | Lock-indicator enable bit |
| spur_ctl | output | 1 | Spur control bit |
| main_b | output | 4 | Main divider B count |
| main_a | output | 3 | Main divider A count |
| main_fn | output | 11 | Fractional numerator |
| main_en | output | 1 | Main synthesizer enable |
| if_en | output | 1 | IF synthesizer enable |
| ctrl_misc | output | 20 | Register 1 bits [23:4] |
| aux_misc | output | 22 | Register 2 bits [23:2] |
| loop_misc | output | 21 | Register 3 bits [23:3] |
| if_a | output | 4 | Effective IF A count |
| if_b | output | 9 | Effective IF B count |
| if_r | output | 9 | Effective IF reference count |

## Verification
A table of words visits every address code, including a test-register write and a discarded all-ones code. A word-by-word comparison against a model separates misrouted addresses from misplaced fields. The words toggle default-select before and after the IF registers are written, which shows whether defaults mask stored values or overwrite them. Directed cases cover a half-shifted word with no latch strobe and a reset taken mid-run, which tell a premature commit apart from a wrong reset value.

// File: rtl/cfgld_pkg.sv
// Package: shared constants and field positions for the serial config loader.
// Assumes a fixed 24-bit word with the address code in its low bits.
package cfgld_pkg;
    localparam int WORD_W     = 24;
    localparam int NUM_REGS   = 7;
    localparam int MAX_CODE_W = NUM_REGS - 1;

    typedef enum logic [2:0] {
        REG_MAIN = 3'd0,
        REG_CTRL = 3'd1,
        REG_AUX  = 3'd2,
        REG_LOOP = 3'd3,
        REG_IFN  = 3'd4,
        REG_IFR  = 3'd5,
        REG_TEST = 3'd6
    } reg_id_e;

    // register 0 fields
    localparam int R0_DFLT   = 23;
    localparam int R0_BAND   = 22;
    localparam int R0_LDEN   = 21;
    localparam int R0_SPUR   = 20;
    localparam int B_W       = 4;
    localparam int R0_B_LSB  = 16;
    localparam int A_W       = 3;
    localparam int R0_A_LSB  = 13;
    localparam int FN_W      = 11;
    localparam int R0_FN_LSB = 2;

    // register 1..3 fields
    localparam int R1_MAIN_EN  = 3;
    localparam int R1_IF_EN    = 2;
    localparam int R1_MISC_LSB = 4;
    localparam int R2_MISC_LSB = 2;
    localparam int R3_MISC_LSB = 3;
    localparam int R1_MISC_W   = WORD_W - R1_MISC_LSB;
    localparam int R2_MISC_W   = WORD_W - R2_MISC_LSB;
    localparam int R3_MISC_W   = WORD_W - R3_MISC_LSB;

    // IF divider fields
    localparam int IFA_W       = 4;
    localparam int R4_IFA_LSB  = 13;
    localparam int IFB_W       = 9;
    localparam int R4_IFB_LSB  = 4;
    localparam int IFR_W       = 9;
    localparam int R5_IFR_LSB  = 5;
endpackage

// File: rtl/cfgld_sync.sv
// Module: multi-bit input synchronizer.
// Each bit passes through its own STAGES-deep flop chain. Assumes STAGES >= 2.
// The chain resets to ones, so a line held high across reset yields no edge.
module cfgld_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe;

        // shift the raw line through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], d[g]};
        end

        assign q[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/cfgld_shifter.sv
// Module: edge detection and serial-to-parallel shift register.
// Inputs are already synchronized. Bits enter at the LSB, so the first bit
// ends up at the MSB.
module cfgld_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              sle_s,
    output logic [WORD_W-1:0] word,
    output logic              sclk_rise,
    output logic              le_rise
);
    logic sclk_d;
    logic sle_d;

    // remember the previous level of the shift clock and latch strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            sle_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            sle_d  <= sle_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign le_rise   = sle_s  & ~sle_d;

    // accept one data bit per rising edge of the shift clock
    always_ff @(posedge clk) begin
        if (!rst_n)         word <= '0;
        else if (sclk_rise) word <= {word[WORD_W-2:0], sdata_s};
    end
endmodule

// File: rtl/cfgld_decode.sv
// Module: prefix address decoder.
// Two-bit codes other than 11 select registers 0..2. With 11, the run of ones
// from bit 0 selects the higher registers. A code of all ones selects nothing.
module cfgld_decode #(
    parameter int NUM_REGS   = 7,
    parameter int MAX_CODE_W = 6
) (
    input  logic [MAX_CODE_W-1:0] code,
    output logic [NUM_REGS-1:0]   sel
);
    // build a one-hot (or empty) register select from the address code
    always_comb begin
        logic found;
        sel   = '0;
        found = 1'b0;
        if (code[1:0] != 2'b11) begin
            sel[code[1:0]] = 1'b1;
        end else begin
            for (int k = 2; k < MAX_CODE_W; k++) begin
                if (!found && !code[k] && (k + 1 < NUM_REGS)) begin
                    sel[k+1] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfgld_regfile.sv
// Module: register bank plus field extraction and default-value selection.
// Register 0 resets with default-select set. The others reset to zero.
// Register 6 is stored but drives nothing.
module cfgld_regfile
    import cfgld_pkg::*;
#(
    parameter int DEF_IF_A = 9,
    parameter int DEF_IF_B = 229,
    parameter int DEF_IF_R = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [NUM_REGS-1:0]  sel,
    input  logic [WORD_W-1:0]    word,
    output logic                 dflt_sel,
    output logic                 band_sel,
    output logic                 lock_ind_en,
    output logic                 spur_ctl,
    output logic [B_W-1:0]       main_b,
    output logic [A_W-1:0]       main_a,
    output logic [FN_W-1:0]      main_fn,
    output logic                 main_en,
    output logic                 if_en,
    output logic [R1_MISC_W-1:0] ctrl_misc,
    output logic [R2_MISC_W-1:0] aux_misc,
    output logic [R3_MISC_W-1:0] loop_misc,
    output logic [IFA_W-1:0]     if_a,
    output logic [IFB_W-1:0]     if_b,
    output logic [IFR_W-1:0]     if_r
);
    localparam logic [IFA_W-1:0] DEF_A_V = DEF_IF_A[IFA_W-1:0];
    localparam logic [IFB_W-1:0] DEF_B_V = DEF_IF_B[IFB_W-1:0];
    localparam logic [IFR_W-1:0] DEF_R_V = DEF_IF_R[IFR_W-1:0];

    logic [WORD_W-1:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [WORD_W-1:0] RST_V =
            (g == int'(REG_MAIN)) ? (WORD_W'(1) << R0_DFLT) : '0;
        logic [WORD_W-1:0] q;

        // capture the word when this register is addressed at latch time
        always_ff @(posedge clk) begin
            if (!rst_n)           q <= RST_V;
            else if (wr && sel[g]) q <= word;
        end

        assign bank[g] = q;
    end

    logic [WORD_W-1:0] r0, r1, r2, r3, r4, r5;
    assign r0 = bank[REG_MAIN];
    assign r1 = bank[REG_CTRL];
    assign r2 = bank[REG_AUX];
    assign r3 = bank[REG_LOOP];
    assign r4 = bank[REG_IFN];
    assign r5 = bank[REG_IFR];

    // main register fields
    assign dflt_sel    = r0[R0_DFLT];
    assign band_sel    = r0[R0_BAND];
    assign lock_ind_en = r0[R0_LDEN];
    assign spur_ctl    = r0[R0_SPUR];
    assign main_b      = r0[R0_B_LSB  +: B_W];
    assign main_a      = r0[R0_A_LSB  +: A_W];
    assign main_fn     = r0[R0_FN_LSB +: FN_W];

    // control and auxiliary fields
    assign main_en   = r1[R1_MAIN_EN];
    assign if_en     = r1[R1_IF_EN];
    assign ctrl_misc = r1[R1_MISC_LSB +: R1_MISC_W];
    assign aux_misc  = r2[R2_MISC_LSB +: R2_MISC_W];
    assign loop_misc = r3[R3_MISC_LSB +: R3_MISC_W];

    // IF fields: built-in defaults mask the user registers while selected
    always_comb begin
        if (dflt_sel) begin
            if_a = DEF_A_V;
            if_b = DEF_B_V;
            if_r = DEF_R_V;
        end else begin
            if_a = r4[R4_IFA_LSB +: IFA_W];
            if_b = r4[R4_IFB_LSB +: IFB_W];
            if_r = r5[R5_IFR_LSB +: IFR_W];
        end
    end

    logic unused_bank_bits;
    assign unused_bank_bits = ^{r0[R0_FN_LSB-1:0], r1[R1_IF_EN-1:0], r2[R2_MISC_LSB-1:0],
                                r3[R3_MISC_LSB-1:0], r4[WORD_W-1:R4_IFA_LSB+IFA_W],
                                r4[R4_IFB_LSB-1:0], r5[WORD_W-1:R5_IFR_LSB+IFR_W],
                                r5[R5_IFR_LSB-1:0], bank[REG_TEST]};
endmodule

// File: rtl/tri_wire_cfg_loader.sv
// Module: top of the three-wire configuration loader.
// It synchronizes the serial lines, shifts in 24-bit words, decodes the
// prefix address and commits the word on a rising latch strobe.
// Assumes each serial line phase lasts more than SYNC_STAGES+1 clk cycles.
module tri_wire_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEF_IF_A    = 9,
    parameter int DEF_IF_B    = 229,
    parameter int DEF_IF_R    = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 ser_latch,
    output logic                 dflt_sel,
    output logic                 band_sel,
    output logic                 lock_ind_en,
    output logic                 spur_ctl,
    output logic [B_W-1:0]       main_b,
    output logic [A_W-1:0]       main_a,
    output logic [FN_W-1:0]      main_fn,
    output logic                 main_en,
    output logic                 if_en,
    output logic [R1_MISC_W-1:0] ctrl_misc,
    output logic [R2_MISC_W-1:0] aux_misc,
    output logic [R3_MISC_W-1:0] loop_misc,
    output logic [IFA_W-1:0]     if_a,
    output logic [IFB_W-1:0]     if_b,
    output logic [IFR_W-1:0]     if_r
);
    logic [2:0]          lines_s;
    logic                sclk_s, sdata_s, sle_s;
    logic [WORD_W-1:0]   word;
    logic                sclk_rise, le_rise;
    logic [NUM_REGS-1:0] sel;

    cfgld_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_latch, ser_data, ser_clk}),
        .q     (lines_s)
    );

    assign sclk_s  = lines_s[0];
    assign sdata_s = lines_s[1];
    assign sle_s   = lines_s[2];

    cfgld_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sdata_s   (sdata_s),
        .sle_s     (sle_s),
        .word      (word),
        .sclk_rise (sclk_rise),
        .le_rise   (le_rise)
    );

    cfgld_decode #(.NUM_REGS(NUM_REGS), .MAX_CODE_W(MAX_CODE_W)) u_dec (
        .code (word[MAX_CODE_W-1:0]),
        .sel  (sel)
    );

    cfgld_regfile #(.DEF_IF_A(DEF_IF_A), .DEF_IF_B(DEF_IF_B), .DEF_IF_R(DEF_IF_R)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (le_rise),
        .sel         (sel),
        .word        (word),
        .dflt_sel    (dflt_sel),
        .band_sel    (band_sel),
        .lock_ind_en (lock_ind_en),
        .spur_ctl    (spur_ctl),
        .main_b      (main_b),
        .main_a      (main_a),
        .main_fn     (main_fn),
        .main_en     (main_en),
        .if_en       (if_en),
        .ctrl_misc   (ctrl_misc),
        .aux_misc    (aux_misc),
        .loop_misc   (loop_misc),
        .if_a        (if_a),
        .if_b        (if_b),
        .if_r        (if_r)
    );

    logic unused_edge;
    assign unused_edge = sclk_rise;
endmodule

// File: rtl/cfgld_checker.sv
// Module: assertion checker bound to the loader top.
// It watches internal strobes, the shift word, the decoder select and the outputs.
module cfgld_checker #(
    parameter int DEF_IF_A = 9,
    parameter int DEF_IF_B = 229,
    parameter int DEF_IF_R = 160
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclk_rise,
    input logic          le_rise,
    input logic          data_bit,
    input logic [23:0]   word,
    input logic [6:0]    sel,
    input logic          dflt_sel,
    input logic          main_en,
    input logic          if_en,
    input logic [3:0]    main_b,
    input logic [10:0]   main_fn,
    input logic [3:0]    if_a,
    input logic [8:0]    if_b,
    input logic [8:0]    if_r,
    input logic [108:0]  out_bus
);
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> word[0] == $past(data_bit)); // R1

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R3

    AST_CODE_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word[1:0] == 2'b10) |-> sel[2]); // R3

    AST_R0_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && sel[0]) |=> (main_b == $past(word[19:16])) && (main_fn == $past(word[12:2]))); // R4

    AST_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && sel[1]) |=> (main_en == $past(word[3])) && (if_en == $past(word[2]))); // R5

    AST_USER_IF: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && sel[4] && !dflt_sel) |=> (if_a == $past(word[16:13])) && (if_b == $past(word[12:4]))); // R6

    AST_DEFAULT_IF: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && sel[0] && word[23]) |=>
            (if_a == 4'(DEF_IF_A)) && (if_b == 9'(DEF_IF_B)) && (if_r == 9'(DEF_IF_R))); // R7

    AST_NO_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(out_bus)); // R8

    AST_TEST_REG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && (sel[6] || sel == 7'b0)) |=> $stable(out_bus)); // R9
endmodule

bind tri_wire_cfg_loader cfgld_checker #(
    .DEF_IF_A(DEF_IF_A), .DEF_IF_B(DEF_IF_B), .DEF_IF_R(DEF_IF_R)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .le_rise   (le_rise),
    .data_bit  (sdata_s),
    .word      (word),
    .sel       (sel),
    .dflt_sel  (dflt_sel),
    .main_en   (main_en),
    .if_en     (if_en),
    .main_b    (main_b),
    .main_fn   (main_fn),
    .if_a      (if_a),
    .if_b      (if_b),
    .if_r      (if_r),
    .out_bus   ({dflt_sel, band_sel, lock_ind_en, spur_ctl, main_b, main_a, main_fn,
                 main_en, if_en, ctrl_misc, aux_misc, loop_misc, if_a, if_b, if_r})
);

// File: tb/sim_tri_wire_cfg_loader.sv
// Bench: a word table walked by one loop against a requirement model, then
// directed reset, partial-word and discard cases.
module sim_tri_wire_cfg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
    logic        dflt_sel, band_sel, lock_ind_en, spur_ctl, main_en, if_en;
    logic [3:0]  main_b;
    logic [2:0]  main_a;
    logic [10:0] main_fn;
    logic [19:0] ctrl_misc;
    logic [21:0] aux_misc;
    logic [20:0] loop_misc;
    logic [3:0]  if_a;
    logic [8:0]  if_b, if_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    tri_wire_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch(ser_latch),
        .dflt_sel(dflt_sel), .band_sel(band_sel), .lock_ind_en(lock_ind_en), .spur_ctl(spur_ctl),
        .main_b(main_b), .main_a(main_a), .main_fn(main_fn), .main_en(main_en), .if_en(if_en),
        .ctrl_misc(ctrl_misc), .aux_misc(aux_misc), .loop_misc(loop_misc),
        .if_a(if_a), .if_b(if_b), .if_r(if_r)
    );

    localparam int NV = 13;
    localparam logic [23:0] VEC [NV] = '{
        {20'hA5A5A, 1'b1, 1'b0, 2'b01},                                   // 0 reg1
        {22'h2AB3C1, 2'b10},                                              // 1 reg2
        {21'h15ACE7, 3'b011},                                             // 2 reg3
        {7'h00, 4'd7, 9'd300, 4'b0111},                                   // 3 reg4
        {10'h000, 9'd200, 5'b01111},                                      // 4 reg5
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd11, 3'd4, 11'd1104, 2'b00},           // 5 reg0, user IF
        {20'h0F0F0, 1'b0, 1'b1, 2'b01},                                   // 6 reg1
        {18'h3FFFF, 6'b011111},                                           // 7 reg6 test
        {18'h12345, 6'b111111},                                           // 8 discarded
        {7'h7F, 4'd15, 9'd511, 4'b0111},                                  // 9 reg4
        {1'b1, 1'b0, 1'b0, 1'b1, 4'd2, 3'd7, 11'd1919, 2'b00},            // 10 reg0, defaults
        {10'h3FF, 9'd2, 5'b01111},                                        // 11 reg5 under defaults
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd15, 3'd0, 11'd0, 2'b00}               // 12 reg0, user IF
    };

    // requirement model
    logic [23:0] m0, m1, m2, m3, m4, m5;

    task automatic model_reset();
        m0 = 24'h800000; m1 = '0; m2 = '0; m3 = '0; m4 = '0; m5 = '0;
    endtask

    task automatic model_write(input logic [23:0] w);
        if      (w[1:0] == 2'b00) m0 = w;
        else if (w[1:0] == 2'b01) m1 = w;
        else if (w[1:0] == 2'b10) m2 = w;
        else if (w[2] == 1'b0)    m3 = w;
        else if (w[3] == 1'b0)    m4 = w;
        else if (w[4] == 1'b0)    m5 = w;
        // reg6 and the all-ones code leave every output alone
    endtask

    function automatic logic [108:0] exp_bus();
        logic [3:0] ea; logic [8:0] eb, er;
        ea = m0[23] ? 4'd9   : m4[16:13];
        eb = m0[23] ? 9'd229 : m4[12:4];
        er = m0[23] ? 9'd160 : m5[13:5];
        return {m0[23], m0[22], m0[21], m0[20], m0[19:16], m0[15:13], m0[12:2],
                m1[3], m1[2], m1[23:4], m2[23:2], m3[23:3], ea, eb, er};
    endfunction

    function automatic logic [108:0] dut_bus();
        return {dflt_sel, band_sel, lock_ind_en, spur_ctl, main_b, main_a, main_fn,
                main_en, if_en, ctrl_misc, aux_misc, loop_misc, if_a, if_b, if_r};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [108:0] e;
        e = exp_bus();
        chk("R1 R2 word lands in addressed register", 128'(dut_bus()), 128'(e));
        chk("R4 main register fields", 128'({dflt_sel, band_sel, lock_ind_en, spur_ctl, main_b, main_a, main_fn}),
            128'(e[108:87]));
        chk("R5 enables and ctrl bits", 128'({main_en, if_en, ctrl_misc}), 128'(e[86:65]));
        chk("R3 aux and loop registers", 128'({aux_misc, loop_misc}), 128'(e[64:22]));
        if (m0[23]) chk("R7 default IF values", 128'({if_a, if_b, if_r}), 128'({4'd9, 9'd229, 9'd160}));
        else        chk("R6 user IF values", 128'({if_a, if_b, if_r}), 128'(e[21:0]));
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [23:0] w, input int nbits);
        for (int i = 23; i > 23 - nbits; i--) begin
            ser_data = w[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_word(input logic [23:0] w);
        shift_bits(w, 24);
        wait_clk(4);
        ser_latch = 1'b1;
        wait_clk(4);
        ser_latch = 1'b0;
        wait_clk(8);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        model_reset();
    endtask

    initial begin
        logic [108:0] snap;
        model_reset();
        do_reset();

        // R10 reset state
        chk("R10 reset state", 128'(dut_bus()), 128'(exp_bus()));
        chk("R7 defaults after reset", 128'({dflt_sel, if_a, if_b, if_r}), 128'({1'b1, 4'd9, 9'd229, 9'd160}));

        // table walk
        for (int v = 0; v < NV; v++) begin
            snap = dut_bus();
            send_word(VEC[v]);
            model_write(VEC[v]);
            compare_all();
            if (v == 7) chk("R9 test register write has no effect", 128'(dut_bus()), 128'(snap));
            if (v == 8) chk("R9 all-ones code discarded", 128'(dut_bus()), 128'(snap));
            if (v == 12) chk("R10 stored IF kept under defaults", 128'({if_a, if_b, if_r}),
                             128'({4'd15, 9'd511, 9'd2}));
        end

        // R8 partial word without latch
        snap = dut_bus();
        shift_bits({1'b1, 1'b1, 1'b0, 1'b0, 4'd9, 3'd1, 11'd55, 2'b00}, 15);
        wait_clk(10);
        chk("R8 partial word ignored", 128'(dut_bus()), 128'(snap));
        send_word({1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 3'd5, 11'h401, 2'b00});
        model_write({1'b0, 1'b1, 1'b0, 1'b1, 4'd3, 3'd5, 11'h401, 2'b00});
        chk("R1 MSB-first numerator", 128'(main_fn), 128'(11'h401));
        compare_all();

        // R8 full word shifted, no latch
        snap = dut_bus();
        shift_bits({20'h11111, 1'b0, 1'b0, 2'b01}, 24);
        wait_clk(10);
        chk("R8 complete word without latch ignored", 128'(dut_bus()), 128'(snap));

        // R10 reset mid-run
        do_reset();
        chk("R10 reset after activity", 128'(dut_bus()), 128'(exp_bus()));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule